// File: doc/BRIEF.md
# Data-Strobe Link Character Transmitter

This block turns a stream of parallel link characters into a two-wire data/strobe signal, one bit per clock. On its parallel side it pulls 9-bit words from a show-ahead transmit FIFO. Each word is either a data byte or a packet-end marker. It also takes a level request to emit a flow-control token (FCT) and a one-cycle pulse each time the far end grants a token. After every character it picks what to send next: a requested FCT, a data or packet-end character when credit allows, or a NULL filler. It then adds the parity and flag bits and shifts the character out.

Credit is tracked in the block. Each granted token adds a fixed number of payload credits, up to a ceiling. Each data, end-of-packet or error-end character spends one credit. The FIFO word that goes out next is held in a one-entry staging register, so payload characters follow each other with no idle bit between them.

Top module: `ds_char_tx`

## Requirements
- R1: While `rstN` is low, `dOut`, `sOut`, `fifoRead` and `fctTaken` are all 0. This holds even when the FIFO is not empty.
- R2: From the first clock after reset, exactly one of `dOut` and `sOut` changes on each clock. `dOut` carries the current bit.
- R3: A data character is 10 bits, sent in this order: parity, flag = 0, then the 8 data bits least significant first. Data bytes leave in FIFO order with their values unchanged.
- R4: A control character is 4 bits, sent in this order: parity, flag = 1, then a 2-bit code least significant first. The codes are 00 = FCT, 01 = end of packet, 10 = error end of packet, 11 = escape.
- R5: The parity bit gives odd parity over three things: the parity bit itself, the data or code bits of the previous character, and the flag of the current character. Before the first character after reset, the previous bits count as zero.
- R6: When nothing else is eligible, a NULL is sent. A NULL is an escape character followed at once by an FCT character. An escape is never followed by anything but an FCT.
- R7: A standalone FCT is sent only while `fctPending` is high. It takes priority over payload characters. `fctTaken` pulses for one cycle in the clock before the FCT's first bit appears.
- R8: Each `tokenIn` pulse adds 8 credits, and credit saturates at 56. A payload character is sent only when credit is above zero, and each one sent spends one credit.
- R9: A FIFO word with bit 8 set is a packet end. Its bit 0 picks end of packet (0) or error end (1). Its bits 7..1 are ignored.
- R10: When credit is available and words are queued, payload characters go out back to back, with no control character between them.
- R11: `fifoRead` is high only while `fifoEmpty` is low. Each read takes the word on `fifoData` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoData | input | 9 | Head word of the transmit FIFO (bit 8 = packet-end marker) |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoRead | output | 1 | Pop the head word this cycle |
| fctPending | input | 1 | Request to send a flow-control token |
| fctTaken | output | 1 | The requested token is committed this cycle |
| tokenIn | input | 1 | One-cycle pulse: the far end granted a token |
| dOut | output | 1 | Data line |
| sOut | output | 1 | Strobe line |

## Verification
The bench decodes the line back into characters and checks parity, character type and payload. It does this across several input patterns. First, an idle link with no credit separates NULL filler from stray payload. Next, a single token with a deep queue shows the exact credit count and back-to-back spacing. A token arriving together with an FCT request shows that the request wins. A run of grants while the queue is empty shows the saturation ceiling. Marker words with random upper bits test that those bits are ignored. A long random mix of pushes, grants and FCT requests, followed by a drain, shows that nothing is lost or reordered.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

  localparam int BYTE_W = 8;
  localparam int CODE_W = 2;

  localparam logic [CODE_W-1:0] CODE_FCT = 2'b00;
  localparam logic [CODE_W-1:0] CODE_EOP = 2'b01;
  localparam logic [CODE_W-1:0] CODE_EEP = 2'b10;
  localparam logic [CODE_W-1:0] CODE_ESC = 2'b11;

  typedef enum logic [2:0] {
    CH_ESC,
    CH_FCT,
    CH_DATA,
    CH_EOP,
    CH_EEP
  } charKind_t;

  // Strobes from the control unit to the serializer
  typedef struct packed {
    logic              load;
    charKind_t         kind;
    logic [BYTE_W-1:0] byteVal;
  } txStrobe_t;

  function automatic logic isPayload(charKind_t k);
    return (k == CH_DATA) || (k == CH_EOP) || (k == CH_EEP);
  endfunction

endpackage

// File: rtl/dstx_ctrl.sv
module dstx_ctrl
  import dstx_pkg::*;
#(
  parameter int TOKEN_CREDIT = 8,
  parameter int MAX_CREDIT   = 56,
  localparam int ENTRY_W  = BYTE_W + 1,
  localparam int CREDIT_W = $clog2(MAX_CREDIT + 1),
  localparam int SUM_W    = $clog2(MAX_CREDIT + TOKEN_CREDIT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                charDone,
  input  logic                fctPending,
  input  logic                tokenIn,
  input  logic [ENTRY_W-1:0]  fifoData,
  input  logic                fifoEmpty,
  output txStrobe_t           strobe,
  output logic                fifoRead,
  output logic                fctTaken,
  output logic [CREDIT_W-1:0] credit
);

  logic               stagedValid;
  logic [ENTRY_W-1:0] staged;
  logic               nullHalf;

  logic               go;
  charKind_t          nextKind;
  logic               takeFct;
  logic               spend;
  logic               spendNow;
  logic [SUM_W-1:0]   creditSum;
  logic [CREDIT_W-1:0] creditNext;

  // Character selection, in priority order
  always_comb begin
    go       = charDone && rstN;
    nextKind = CH_ESC;
    takeFct  = 1'b0;
    spend    = 1'b0;
    if (nullHalf) begin
      nextKind = CH_FCT;
    end else if (fctPending) begin
      nextKind = CH_FCT;
      takeFct  = 1'b1;
    end else if (stagedValid && (credit != '0)) begin
      spend = 1'b1;
      if (staged[BYTE_W]) nextKind = staged[0] ? CH_EEP : CH_EOP;
      else                nextKind = CH_DATA;
    end
  end

  always_comb begin
    strobe.load    = go;
    strobe.kind    = nextKind;
    strobe.byteVal = staged[BYTE_W-1:0];
    fctTaken       = go && takeFct;
    spendNow       = go && spend;
    fifoRead       = rstN && !fifoEmpty && (!stagedValid || spendNow);
  end

  // Credit balance with saturation
  always_comb begin
    creditSum = SUM_W'(credit)
              + (tokenIn ? SUM_W'(TOKEN_CREDIT) : SUM_W'(0))
              - SUM_W'(spendNow);
    if (creditSum > SUM_W'(MAX_CREDIT)) creditNext = CREDIT_W'(MAX_CREDIT);
    else                                creditNext = CREDIT_W'(creditSum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedValid <= 1'b0;
      staged      <= '0;
      nullHalf    <= 1'b0;
      credit      <= '0;
    end else begin
      credit <= creditNext;
      if (fifoRead) begin
        stagedValid <= 1'b1;
        staged      <= fifoData;
      end else if (spendNow) begin
        stagedValid <= 1'b0;
      end
      if (go) nullHalf <= (nextKind == CH_ESC);
    end
  end

endmodule

// File: rtl/dstx_serializer.sv
module dstx_serializer
  import dstx_pkg::*;
#(
  localparam int DATA_LEN = BYTE_W + 2,
  localparam int CTRL_LEN = CODE_W + 2,
  localparam int CNT_W    = $clog2(DATA_LEN + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  output logic      charDone,
  output logic      nextBit
);

  logic [DATA_LEN-2:0] shiftReg;
  logic [CNT_W-1:0]    remaining;
  logic                prevXor;

  logic [DATA_LEN-1:0] newChar;
  logic [CODE_W-1:0]   code;
  logic                flag;
  logic                parity;
  logic                newXor;
  logic [CNT_W-1:0]    newLen;

  // Build the next character, LSB-first order: parity, flag, payload
  always_comb begin
    unique case (strobe.kind)
      CH_FCT:  code = CODE_FCT;
      CH_EOP:  code = CODE_EOP;
      CH_EEP:  code = CODE_EEP;
      default: code = CODE_ESC;
    endcase
    flag   = (strobe.kind != CH_DATA);
    parity = ~(prevXor ^ flag);
    if (!flag) begin
      newChar = {strobe.byteVal, flag, parity};
      newXor  = ^strobe.byteVal;
      newLen  = CNT_W'(DATA_LEN);
    end else begin
      newChar = {{(DATA_LEN-CTRL_LEN){1'b0}}, code, flag, parity};
      newXor  = ^code;
      newLen  = CNT_W'(CTRL_LEN);
    end
  end

  assign charDone = (remaining == '0);
  assign nextBit  = strobe.load ? newChar[0] : shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      remaining <= '0;
      prevXor   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg  <= newChar[DATA_LEN-1:1];
      remaining <= newLen - CNT_W'(1);
      prevXor   <= newXor;
    end else if (remaining != '0) begin
      shiftReg  <= shiftReg >> 1;
      remaining <= remaining - CNT_W'(1);
    end
  end

endmodule

// File: rtl/dstx_ds_encoder.sv
module dstx_ds_encoder (
  input  logic clk,
  input  logic rstN,
  input  logic bitIn,
  output logic dLine,
  output logic sLine
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dLine <= 1'b0;
      sLine <= 1'b0;
    end else begin
      dLine <= bitIn;
      if (bitIn == dLine) sLine <= ~sLine;
    end
  end

endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx
  import dstx_pkg::*;
#(
  parameter int TOKEN_CREDIT = 8,
  parameter int MAX_CREDIT   = 56,
  localparam int ENTRY_W  = BYTE_W + 1,
  localparam int CREDIT_W = $clog2(MAX_CREDIT + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRY_W-1:0] fifoData,
  input  logic               fifoEmpty,
  output logic               fifoRead,
  input  logic               fctPending,
  output logic               fctTaken,
  input  logic               tokenIn,
  output logic               dOut,
  output logic               sOut
);

  txStrobe_t           strobe;
  logic                charDone;
  logic                nextBit;
  logic [CREDIT_W-1:0] credit;

  dstx_ctrl #(
    .TOKEN_CREDIT(TOKEN_CREDIT),
    .MAX_CREDIT  (MAX_CREDIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .charDone  (charDone),
    .fctPending(fctPending),
    .tokenIn   (tokenIn),
    .fifoData  (fifoData),
    .fifoEmpty (fifoEmpty),
    .strobe    (strobe),
    .fifoRead  (fifoRead),
    .fctTaken  (fctTaken),
    .credit    (credit)
  );

  dstx_serializer u_ser (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .charDone(charDone),
    .nextBit (nextBit)
  );

  dstx_ds_encoder u_enc (
    .clk  (clk),
    .rstN (rstN),
    .bitIn(nextBit),
    .dLine(dOut),
    .sLine(sOut)
  );

endmodule

// File: rtl/dstx_checker.sv
module dstx_checker
  import dstx_pkg::*;
#(
  parameter int TOKEN_CREDIT = 8,
  parameter int MAX_CREDIT   = 56,
  localparam int CREDIT_W = $clog2(MAX_CREDIT + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                dOut,
  input logic                sOut,
  input logic                fifoRead,
  input logic                fifoEmpty,
  input logic                fctPending,
  input logic                fctTaken,
  input logic                tokenIn,
  input logic                strobeLoad,
  input charKind_t           strobeKind,
  input logic [CREDIT_W-1:0] credit
);

  // R1: quiet lines and no handshakes while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!dOut && !sOut && !fifoRead && !fctTaken)
        else $error("reset outputs not quiet");
    end
  end

  assert_one_line_moves_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((dOut ^ $past(dOut)) ^ (sOut ^ $past(sOut))));

  assert_fct_on_request_R7: assert property (@(posedge clk) disable iff (!rstN)
    fctTaken |-> fctPending);

  assert_credit_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(credit) <= MAX_CREDIT);

  assert_spend_needs_credit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobeLoad && isPayload(strobeKind)) |-> (credit != '0));

  assert_token_refill_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tokenIn && !(strobeLoad && isPayload(strobeKind))
     && (int'(credit) + TOKEN_CREDIT <= MAX_CREDIT))
    |=> (int'(credit) == int'($past(credit)) + TOKEN_CREDIT));

  assert_read_needs_word_R11: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !fifoEmpty);

endmodule

bind ds_char_tx dstx_checker #(
  .TOKEN_CREDIT(TOKEN_CREDIT),
  .MAX_CREDIT  (MAX_CREDIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dOut      (dOut),
  .sOut      (sOut),
  .fifoRead  (fifoRead),
  .fifoEmpty (fifoEmpty),
  .fctPending(fctPending),
  .fctTaken  (fctTaken),
  .tokenIn   (tokenIn),
  .strobeLoad(strobe.load),
  .strobeKind(strobe.kind),
  .credit    (credit)
);

// File: tb/ds_char_tx_test.sv
module ds_char_tx_test;

  localparam int PERIOD = 10;
  localparam int K_FCT  = 0;
  localparam int K_EOP  = 1;
  localparam int K_EEP  = 2;
  localparam int K_ESC  = 3;
  localparam int K_DATA = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [8:0] fifoData;
  logic       fifoEmpty;
  logic       fifoRead;
  logic       fctPending = 1'b0;
  logic       fctTaken;
  logic       tokenIn = 1'b0;
  logic       dOut;
  logic       sOut;

  int checks = 0;
  int errors = 0;

  logic [8:0] mem [256];
  int wrPtr = 0;
  int rdPtr = 0;
  logic popFlag = 1'b0;
  logic takeSeen = 1'b0;
  int fctTakenCnt = 0;
  int fctReqs = 0;
  int tokens = 0;

  assign fifoData  = mem[rdPtr & 255];
  assign fifoEmpty = (rdPtr == wrPtr);

  always #(PERIOD/2) clk = ~clk;

  ds_char_tx uut (
    .clk       (clk),
    .rstN      (rstN),
    .fifoData  (fifoData),
    .fifoEmpty (fifoEmpty),
    .fifoRead  (fifoRead),
    .fctPending(fctPending),
    .fctTaken  (fctTaken),
    .tokenIn   (tokenIn),
    .dOut      (dOut),
    .sOut      (sOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- line decoder ----------------
  int edges = 0;
  always @(posedge clk) begin
    if (!rstN) edges <= 0;
    else       edges <= edges + 1;
  end

  logic prevD = 1'b0, prevS = 1'b0;
  int pos = 0;
  logic par = 1'b0, flg = 1'b0;
  logic [7:0] acc = '0;
  logic lastXor = 1'b0;
  logic escOpen = 1'b0;
  int charIdx = 0;
  int dataCount = 0;
  int nullCount = 0;
  int fctAlone = 0;
  int lastFctIdx = -1;
  int firstKinds [4];
  int dataAt [256];

  function automatic int expectKind(logic [8:0] e);
    if (!e[8]) return K_DATA;
    return e[0] ? K_EEP : K_EOP;
  endfunction

  task automatic finishChar();
    int kind;
    logic px;
    px = flg ? (acc[0] ^ acc[1]) : ^acc;
    check((par ^ lastXor ^ flg) == 1'b1, "R5 parity", int'(par), int'(~(lastXor ^ flg)));
    lastXor = px;
    kind = flg ? int'({acc[1], acc[0]}) : K_DATA;
    if (charIdx < 4) firstKinds[charIdx] = kind;
    if (kind == K_ESC) begin
      check(!escOpen, "R6 escape after escape", 1, 0);
      escOpen = 1'b1;
    end else if (kind == K_FCT) begin
      if (escOpen) nullCount++;
      else begin
        fctAlone++;
        lastFctIdx = charIdx;
      end
      escOpen = 1'b0;
    end else begin
      check(!escOpen, "R6 escape not followed by FCT", kind, K_FCT);
      escOpen = 1'b0;
      if (dataCount < 256) begin
        check(kind == expectKind(mem[dataCount & 255]),
              mem[dataCount & 255][8] ? "R9 marker kind" : "R4 kind", kind,
              expectKind(mem[dataCount & 255]));
        if (kind == K_DATA)
          check(acc == mem[dataCount & 255][7:0], "R3 data byte", int'(acc),
                int'(mem[dataCount & 255][7:0]));
        dataAt[dataCount & 255] = charIdx;
      end
      dataCount++;
    end
    charIdx++;
  endtask

  always @(negedge clk) begin
    if (rstN && edges > 0) begin
      check(((dOut ^ prevD) + (sOut ^ prevS)) == 1, "R2 one line moves",
            int'(dOut ^ prevD) + int'(sOut ^ prevS), 1);
      prevD = dOut;
      prevS = sOut;
      if (pos == 0)      par = dOut;
      else if (pos == 1) flg = dOut;
      else               acc[pos-2] = dOut;
      pos++;
      if (pos >= 4 && pos == (flg ? 4 : 10)) begin
        finishChar();
        pos = 0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cycle();
    #(PERIOD/4);
    popFlag  = fifoRead;
    takeSeen = fctTaken;
    @(posedge clk);
    #1;
    if (popFlag) rdPtr++;
    if (takeSeen) begin
      fctTakenCnt++;
      fctPending = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic push(input logic [8:0] e);
    mem[wrPtr & 255] = e;
    wrPtr++;
  endtask

  task automatic token();
    tokenIn = 1'b1;
    tokens++;
    cycle();
    tokenIn = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    void'($urandom(32'h5eed_0042));
    #1 rstN = 1'b0;
    push(9'h0A5);
    repeat (3) @(negedge clk);
    // R1: quiet during reset though FIFO holds a word
    check(dOut == 1'b0 && sOut == 1'b0, "R1 lines in reset", int'({dOut, sOut}), 0);
    check(fifoRead == 1'b0, "R1 no read in reset", int'(fifoRead), 0);
    check(fctTaken == 1'b0, "R1 no FCT in reset", int'(fctTaken), 0);
    rstN = 1'b1;

    // No credit: only NULLs (R6, R8)
    run(300);
    check(firstKinds[0] == K_ESC, "R6 first char escape", firstKinds[0], K_ESC);
    check(firstKinds[1] == K_FCT, "R6 second char FCT", firstKinds[1], K_FCT);
    check(nullCount > 20, "R6 NULL filler", nullCount, 21);
    check(dataCount == 0, "R8 no payload without credit", dataCount, 0);

    push(9'h03C);
    push(9'h100);  // end of packet
    push(9'h101);  // error end
    push(9'h1FE);  // end of packet, upper bits ignored (R9)
    push(9'h1FF);  // error end, upper bits ignored (R9)
    for (int i = 0; i < 6; i++) push({1'b0, 8'($urandom)});
    run(300);
    check(dataCount == 0, "R8 queued but no credit", dataCount, 0);

    // One token: exactly 8 back to back
    token();
    run(400);
    check(dataCount == 8, "R8 one token grants 8", dataCount, 8);
    for (int k = 0; k < 7; k++)
      check(dataAt[k+1] == dataAt[k] + 1, "R10 back to back", dataAt[k+1], dataAt[k] + 1);

    // FCT request together with fresh credit: FCT wins (R7)
    fctPending = 1'b1;
    fctReqs++;
    token();
    run(200);
    check(fctAlone == 1, "R7 one standalone FCT", fctAlone, 1);
    check(fctTakenCnt == 1, "R7 fctTaken pulses", fctTakenCnt, 1);
    check(lastFctIdx < dataAt[8], "R7 FCT before payload", lastFctIdx, dataAt[8]);
    check(dataCount == 12, "R8 remaining credit used", dataCount, 12);

    // Saturation: credit 4 + 8 tokens clips at 56
    for (int i = 0; i < 8; i++) begin
      token();
      cycle();
    end
    for (int i = 0; i < 60; i++) push({($urandom % 8) == 0, 8'($urandom)});
    run(900);
    check(dataCount == 68, "R8 credit ceiling 56", dataCount, 68);
    token();
    run(200);
    check(dataCount == 72, "R8 after refill", dataCount, 72);
    check(rdPtr == wrPtr, "R11 all words read", rdPtr, wrPtr);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 4 == 0 && wrPtr - dataCount < 150)
        push({($urandom % 8) == 0, 8'($urandom)});
      if ($urandom % 40 == 0) tokenIn = 1'b1;
      if (tokenIn) tokens++;
      if (!fctPending && $urandom % 50 == 0) begin
        fctPending = 1'b1;
        fctReqs++;
      end
      cycle();
      tokenIn = 1'b0;
    end
    for (int j = 0; j < 40 && (dataCount != wrPtr || fctPending); j++) begin
      token();
      run(120);
    end
    run(40);
    check(dataCount == wrPtr, "R3 every word sent in order", dataCount, wrPtr);
    check(dataCount <= tokens * 8, "R8 spend bounded by grants", dataCount, tokens * 8);
    check(fctAlone == fctReqs, "R7 every request honoured once", fctAlone, fctReqs);
    check(fctTakenCnt == fctReqs, "R7 fctTaken count", fctTakenCnt, fctReqs);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule